// File: doc/BRIEF.md
# UART Receiver with Status Flags and Idle Time-out

This block turns an asynchronous serial line into parallel characters. It samples the line on a 16x oversampling tick and confirms each start bit at its middle. It then gathers the data bits least significant first, checks an optional parity bit and tests the stop bit. Each finished character goes into a holding register and raises a data-ready flag. The consumer clears that flag with a read strobe.

Four sticky error flags record parity mismatch, bad stop bit, overrun and line break, and one command clears all four at once. An idle time-out counts bit periods of a quiet line after each received character and raises a flag when the programmed count runs out. A restart command stops that countdown and clears the flag, and the next countdown begins only after another character arrives. All commands are single-cycle strobes that act when high. A low strobe does nothing.

Top module: `uart_rx_tmo`

## Requirements
- R1: A frame is one low start bit, DATA_W data bits sent least significant bit first, one parity bit when par_en is 1, then one stop bit, with each bit lasting 16 baud ticks. A frame with a high stop bit loads rx_data and sets rx_ready, and rd_strobe clears rx_ready.
- R2: The receiver is off after reset. cmd_rx_en turns it on only when cmd_rx_dis is 0 in the same cycle, and cmd_rx_dis turns it off. While the receiver is off, no character is received. A strobe held at 0 has no effect.
- R3: With par_odd = 0, the expected parity bit is the XOR of the data bits. With par_odd = 1, it is the inverse of that XOR. When par_en is 1 and the received parity bit differs from the expected one, err_par is set and the character is still delivered.
- R4: If a character completes while rx_ready is still set, err_ovr is set and the new character replaces the old one.
- R5: A stop bit sampled low with at least one data bit high sets err_frm, and the character is still delivered.
- R6: If every data bit and the stop bit sample low, the frame is a break. A break sets rx_brk, leaves rx_data and rx_ready unchanged, and sets neither err_par nor err_frm.
- R7: Error flags stay set until cmd_clr_stat, which clears err_par, err_frm, err_ovr and rx_brk together and leaves rx_ready unchanged.
- R8: A start bit is accepted only if the line is still low 8 ticks after the first low sample, so a low pulse shorter than half a bit is ignored.
- R9: cmd_rx_rst stops any frame in progress and clears rx_ready, and the receiver stays on.
- R10: Each received character loads tmo_val into the time-out counter. The counter decreases once every 16 ticks while the receiver is idle, and tmo_flag is set when it reaches zero. tmo_flag stays set, and a tmo_val of 0 never sets it.
- R11: cmd_sta_tmo clears tmo_flag and stops any countdown. No new countdown starts until the next character completes.
- R12: After reset, rx_ready, rx_data, all error flags and tmo_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Serial line, already synchronous to clk, idles high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | Expect a parity bit after the data bits |
| par_odd | input | 1 | Select odd parity (1) or even parity (0) |
| tmo_val | input | TMO_W | Time-out length in bit periods, 0 turns it off |
| cmd_rx_en | input | 1 | Strobe: turn the receiver on |
| cmd_rx_dis | input | 1 | Strobe: turn the receiver off |
| cmd_rx_rst | input | 1 | Strobe: reset the receive path |
| cmd_clr_stat | input | 1 | Strobe: clear all error flags |
| cmd_sta_tmo | input | 1 | Strobe: stop the countdown and clear tmo_flag |
| rd_strobe | input | 1 | Consumer has taken rx_data |
| rx_data | output | DATA_W | Last received character |
| rx_ready | output | 1 | Unread character present |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun |
| rx_brk | output | 1 | Sticky break received |
| tmo_flag | output | 1 | Idle time-out expired |

## Verification
The assertions check every cycle that an overrun only ever follows a set data-ready flag. They also check that an off receiver never raises data-ready, that a receiver reset drops data-ready, that a break leaves the data register alone, and that the clear and restart commands empty their flags. Only the bench scenarios can show that bits are put together in the right order with the right parity, that a short glitch is dropped, and that the time-out fires after the right number of bit periods. The same scenarios show that the time-out stays quiet after a restart until a new character arrives.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive path.
// Assumes nothing beyond IEEE 1800-2017 packages.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // line high, waiting for a falling sample
        ST_START,  // confirming the start bit at mid-bit
        ST_DATA,   // shifting data bits
        ST_PAR,    // sampling the parity bit
        ST_STOP,   // sampling the stop bit
        ST_HOLD    // stop sampled low, wait for the line to go high
    } rx_state_t;
endpackage

// File: rtl/rx_frame.sv
// Oversampling frame engine: finds a start bit, confirms it at mid-bit,
// samples data, parity and stop bits at their centres and reports a
// finished frame for one cycle on done.
// Assumes rx is synchronous to clk and tick is a one-cycle pulse at
// OVS times the bit rate. clr holds the engine in idle.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              rx,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] d_data,
    output logic              d_par_err,
    output logic              d_frm_err,
    output logic              d_brk,
    output logic              idle
);
    localparam int OVS_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    rx_state_t         state;
    logic [OVS_W-1:0]  os_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              exp_par;

    // Purpose: step the frame state machine on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state   <= ST_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    os_cnt <= '0;
                    if (!rx) state <= ST_START;
                end
                ST_START: begin
                    if (os_cnt == MID) begin
                        os_cnt  <= '0;
                        bit_idx <= '0;
                        state   <= rx ? ST_IDLE : ST_DATA;
                    end else begin
                        os_cnt <= os_cnt + OVS_W'(1);
                    end
                end
                ST_DATA: begin
                    if (os_cnt == LAST) begin
                        os_cnt <= '0;
                        shreg  <= {rx, shreg[DATA_W-1:1]};
                        if (bit_idx == TOP) state <= par_en ? ST_PAR : ST_STOP;
                        else                bit_idx <= bit_idx + IDX_W'(1);
                    end else begin
                        os_cnt <= os_cnt + OVS_W'(1);
                    end
                end
                ST_PAR: begin
                    if (os_cnt == LAST) begin
                        os_cnt  <= '0;
                        par_bit <= rx;
                        state   <= ST_STOP;
                    end else begin
                        os_cnt <= os_cnt + OVS_W'(1);
                    end
                end
                ST_STOP: begin
                    if (os_cnt == LAST) begin
                        os_cnt <= '0;
                        state  <= rx ? ST_IDLE : ST_HOLD;
                    end else begin
                        os_cnt <= os_cnt + OVS_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (rx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the finished frame at the stop-bit sample.
    always_comb begin
        done      = tick && (state == ST_STOP) && (os_cnt == LAST) && !clr;
        d_data    = shreg;
        exp_par   = par_odd ? ~(^shreg) : (^shreg);
        d_brk     = !rx && (shreg == '0);
        d_frm_err = !rx && !d_brk;
        d_par_err = par_en && (par_bit != exp_par) && !d_brk;
        idle      = (state == ST_IDLE);
    end

    // R8: a start bit that fails its mid-bit check goes back to idle
    a_r8_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && state == ST_START && os_cnt == MID && rx) |=> (state == ST_IDLE));
endmodule

// File: rtl/rx_timeout.sv
// Idle time-out counter. It loads a bit-period count when a character
// completes and counts it down while the receiver is idle. At zero it
// sets a sticky flag. A restart strobe clears the flag and disarms.
// Assumes tick is the OVS-times oversampling pulse.
module rx_timeout #(
    parameter int TMO_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle,
    input  logic             load,
    input  logic [TMO_W-1:0] tmo_val,
    input  logic             restart,
    output logic             tmo_flag
);
    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

    logic             armed;
    logic [TMO_W-1:0] cnt;
    logic [OVS_W-1:0] pre;

    // Purpose: arm, count bit periods while idle, and raise the flag at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            cnt      <= '0;
            pre      <= '0;
            tmo_flag <= 1'b0;
        end else begin
            if (restart) begin
                armed    <= 1'b0;
                tmo_flag <= 1'b0;
            end
            if (load) begin
                cnt   <= tmo_val;
                pre   <= '0;
                armed <= (tmo_val != '0);
            end else if (armed && !restart && tick && idle) begin
                if (pre == LAST) begin
                    pre <= '0;
                    if (cnt == TMO_W'(1)) begin
                        cnt      <= '0;
                        armed    <= 1'b0;
                        tmo_flag <= 1'b1;
                    end else begin
                        cnt <= cnt - TMO_W'(1);
                    end
                end else begin
                    pre <= pre + OVS_W'(1);
                end
            end
        end
    end

    // R11: restart always leaves the flag clear
    a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tmo_flag);
    // R10: the flag only rises from an armed countdown
    a_r10_flag_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(armed));
endmodule

// File: rtl/uart_rx_tmo.sv
// UART receiver top. It holds the on/off state, the received-character
// register, the sticky error flags and the idle time-out.
// Assumes rx_in is already synchronous to clk and that baud_tick runs at
// 16 times the bit rate. All cmd_* inputs are one-cycle strobes.
module uart_rx_tmo #(
    parameter int DATA_W = 8,
    parameter int TMO_W  = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [TMO_W-1:0]  tmo_val,
    input  logic              cmd_rx_en,
    input  logic              cmd_rx_dis,
    input  logic              cmd_rx_rst,
    input  logic              cmd_clr_stat,
    input  logic              cmd_sta_tmo,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr,
    output logic              rx_brk,
    output logic              tmo_flag
);
    logic              rx_on;
    logic              eng_clr;
    logic              done;
    logic [DATA_W-1:0] d_data;
    logic              d_par_err;
    logic              d_frm_err;
    logic              d_brk;
    logic              eng_idle;

    assign eng_clr = !rx_on || cmd_rx_rst;

    // Purpose: receiver on/off state, where disable beats enable.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_on <= 1'b0;
        else if (cmd_rx_dis) rx_on <= 1'b0;
        else if (cmd_rx_en)  rx_on <= 1'b1;
    end

    rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (eng_clr),
        .tick      (baud_tick),
        .rx        (rx_in),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .done      (done),
        .d_data    (d_data),
        .d_par_err (d_par_err),
        .d_frm_err (d_frm_err),
        .d_brk     (d_brk),
        .idle      (eng_idle)
    );

    rx_timeout #(.TMO_W(TMO_W), .OVS(OVS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .idle     (eng_idle),
        .load     (done),
        .tmo_val  (tmo_val),
        .restart  (cmd_sta_tmo),
        .tmo_flag (tmo_flag)
    );

    // Purpose: character register and data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (cmd_rx_rst) begin
            rx_ready <= 1'b0;
        end else if (done && !d_brk) begin
            rx_data  <= d_data;
            rx_ready <= 1'b1;
        end else if (rd_strobe) begin
            rx_ready <= 1'b0;
        end
    end

    // Purpose: sticky error flags. A new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_par <= 1'b0;
            err_frm <= 1'b0;
            err_ovr <= 1'b0;
            rx_brk  <= 1'b0;
        end else begin
            if (cmd_clr_stat) begin
                err_par <= 1'b0;
                err_frm <= 1'b0;
                err_ovr <= 1'b0;
                rx_brk  <= 1'b0;
            end
            if (done) begin
                if (d_brk)     rx_brk  <= 1'b1;
                if (d_par_err) err_par <= 1'b1;
                if (d_frm_err) err_frm <= 1'b1;
                if (!d_brk && rx_ready && !rd_strobe) err_ovr <= 1'b1;
            end
        end
    end

    // R4: an overrun is only flagged over an unread character
    a_r4_ovr_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(rx_ready));
    // R2: an off receiver never raises data-ready
    a_r2_off_no_char: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> !$rose(rx_ready));
    // R9: receiver reset drops data-ready
    a_r9_rst_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_rst |=> !rx_ready);
    // R7: clear without a new event empties every error flag
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_stat && !done) |=> !(err_par || err_frm || err_ovr || rx_brk));
    // R6: a break leaves the character register alone
    a_r6_brk_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_brk) |-> $stable(rx_data));
endmodule

// File: tb/uart_rx_tmo_bench.sv
// Bench for uart_rx_tmo: sends frames bit by bit and computes every
// expected value from the requirements.
module uart_rx_tmo_bench;
    localparam int BIT_CLK = 32;  // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [7:0] tmo_val = 8'd0;
    logic       cmd_rx_en = 1'b0, cmd_rx_dis = 1'b0, cmd_rx_rst = 1'b0;
    logic       cmd_clr_stat = 1'b0, cmd_sta_tmo = 1'b0, rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_par, err_frm, err_ovr, rx_brk, tmo_flag;
    logic       tdiv = 1'b0;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    // Oversampling tick every second clock, changed away from the active edge.
    always @(negedge clk) begin
        tdiv      <= ~tdiv;
        baud_tick <= tdiv;
    end

    uart_rx_tmo u_uart_rx_tmo (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .par_en(par_en), .par_odd(par_odd), .tmo_val(tmo_val),
        .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis), .cmd_rx_rst(cmd_rx_rst),
        .cmd_clr_stat(cmd_clr_stat), .cmd_sta_tmo(cmd_sta_tmo), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_par(err_par), .err_frm(err_frm),
        .err_ovr(err_ovr), .rx_brk(rx_brk), .tmo_flag(tmo_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line(input logic b);
        rx_in = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic flip, input logic stop_v);
        logic p;
        p = (par_odd ? ~(^d) : (^d)) ^ flip;
        line(1'b0);
        for (int i = 0; i < 8; i++) line(d[i]);
        if (par_en) line(p);
        line(stop_v);
        line(1'b1);
    endtask

    // Strobe vector order: {rd, rst, clr, sta, en, dis}
    task automatic cmd(input logic [5:0] v);
        {rd_strobe, cmd_rx_rst, cmd_clr_stat, cmd_sta_tmo, cmd_rx_en, cmd_rx_dis} = v;
        @(negedge clk);
        {rd_strobe, cmd_rx_rst, cmd_clr_stat, cmd_sta_tmo, cmd_rx_en, cmd_rx_dis} = 6'b0;
        @(negedge clk);
    endtask

    task automatic flags(input string req, input logic [3:0] exp);
        chk(req, 32'({err_par, err_frm, err_ovr, rx_brk}), 32'(exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 ready", 32'(rx_ready), 0);
        chk("R12 data", 32'(rx_data), 0);
        flags("R12 flags", 4'b0);
        chk("R12 tmo", 32'(tmo_flag), 0);

        // R2: off after reset, enable blocked by disable in the same write
        send(8'h5A, 1'b0, 1'b1);
        chk("R2 off after reset", 32'(rx_ready), 0);
        cmd(6'b000011);
        cmd(6'b000000);
        send(8'h5A, 1'b0, 1'b1);
        chk("R2 en with dis", 32'(rx_ready), 0);
        cmd(6'b000010);
        send(8'h3C, 1'b0, 1'b1);
        chk("R2 enabled ready", 32'(rx_ready), 1);
        chk("R2 enabled data", 32'(rx_data), 32'h3C);
        cmd(6'b100000);
        chk("R1 read clears", 32'(rx_ready), 0);

        // R1/R3 sweep: all codes, parity on for the upper half, odd when bit0 set
        for (int i = 0; i < 256; i++) begin
            par_en  = i[7];
            par_odd = i[0];
            send(8'(i), 1'b0, 1'b1);
            chk("R1 sweep data", 32'(rx_data), 32'(i));
            chk("R1 sweep ready", 32'(rx_ready), 1);
            flags("R3 sweep clean", 4'b0);
            cmd(6'b100000);
        end

        // R3: wrong parity, even then odd
        par_en = 1'b1; par_odd = 1'b0;
        send(8'hA7, 1'b1, 1'b1);
        flags("R3 even mismatch", 4'b1000);
        chk("R3 data kept", 32'(rx_data), 32'hA7);
        cmd(6'b101000);
        flags("R7 clear", 4'b0);
        par_odd = 1'b1;
        send(8'h12, 1'b1, 1'b1);
        flags("R3 odd mismatch", 4'b1000);
        cmd(6'b101000);

        // R4: two characters without a read
        par_en = 1'b0;
        send(8'h21, 1'b0, 1'b1);
        send(8'h43, 1'b0, 1'b1);
        flags("R4 overrun", 4'b0010);
        chk("R4 newest kept", 32'(rx_data), 32'h43);
        cmd(6'b101000);

        // R5: low stop bit with data
        send(8'h81, 1'b0, 1'b0);
        flags("R5 framing", 4'b0100);
        chk("R5 delivered", 32'(rx_data), 32'h81);
        cmd(6'b101000);

        // R6: break with a mismatching parity bit
        par_en = 1'b1; par_odd = 1'b1;
        send(8'h00, 1'b1, 1'b0);
        flags("R6 break only", 4'b0001);
        chk("R6 no ready", 32'(rx_ready), 0);
        chk("R6 data kept", 32'(rx_data), 32'h81);

        // R7: set all four, then one clear
        send(8'h81, 1'b0, 1'b0);
        send(8'h11, 1'b1, 1'b1);
        flags("R7 all set", 4'b1111);
        cmd(6'b001000);
        flags("R7 all cleared", 4'b0);
        chk("R7 ready untouched", 32'(rx_ready), 1);
        cmd(6'b100000);
        par_en = 1'b0;

        // R8: low pulse of 6 ticks is ignored
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        chk("R8 glitch ignored", 32'(rx_ready), 0);
        send(8'h96, 1'b0, 1'b1);
        chk("R8 next char", 32'(rx_data), 32'h96);

        // R9: reset clears ready and aborts a frame
        cmd(6'b010000);
        chk("R9 ready cleared", 32'(rx_ready), 0);
        line(1'b0);
        line(1'b1);
        line(1'b1);
        cmd(6'b010000);
        repeat (9 * BIT_CLK) @(negedge clk);
        chk("R9 frame aborted", 32'(rx_ready), 0);
        send(8'h42, 1'b0, 1'b1);
        chk("R9 still on", 32'(rx_data), 32'h42);
        cmd(6'b100000);

        // R10: 3 bit periods expire 96 clocks after the stop sample
        tmo_val = 8'd3;
        send(8'h55, 1'b0, 1'b1);
        chk("R10 not yet", 32'(tmo_flag), 0);
        repeat (30) @(negedge clk);
        chk("R10 still counting", 32'(tmo_flag), 0);
        repeat (40) @(negedge clk);
        chk("R10 expired", 32'(tmo_flag), 1);
        repeat (200) @(negedge clk);
        chk("R10 sticky", 32'(tmo_flag), 1);

        // R11: restart clears and waits for the next character
        cmd(6'b000100);
        chk("R11 cleared", 32'(tmo_flag), 0);
        repeat (400) @(negedge clk);
        chk("R11 no new count", 32'(tmo_flag), 0);
        send(8'h66, 1'b0, 1'b1);
        repeat (150) @(negedge clk);
        chk("R11 next char rearms", 32'(tmo_flag), 1);
        cmd(6'b100100);
        send(8'h77, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        cmd(6'b100100);
        repeat (200) @(negedge clk);
        chk("R11 countdown aborted", 32'(tmo_flag), 0);

        // R10: value zero never expires
        tmo_val = 8'd0;
        send(8'h88, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        chk("R10 zero disables", 32'(tmo_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule